// File: doc/BRIEF.md
# PLL Phase Lock Detector

This block judges whether a phase-locked loop has settled by watching the reference-divider output and the feedback-divider output. Both arrive asynchronously and are sampled in a fast system clock domain. For every comparison cycle it counts the sample-clock cycles between the rising edge that comes first and the rising edge of the other signal. It then checks that distance against a window chosen by a 2-bit select.

A lock flag is raised only after a run of successive in-window comparisons. The run length is chosen by a second 2-bit select. An unlock flag is raised on the very first out-of-window comparison and drops on the first in-window one. A measurement whose second edge is late is declared out of window as soon as the window time has passed, so a stalled divider is reported without waiting for the missing edge. The detector is inert while its enable input is low.

Top module: `phase_lock_monitor`

## Requirements
- R1: The window select picks a threshold T of 3, 10, 30 or 90 sample cycles for codes 0, 1, 2 and 3. A comparison is in window when the edge distance in cycles is strictly below T, and out of window when it is T or more.
- R2: The count select picks a run length N of 32, 128, 512 or 2048 for codes 0, 1, 2 and 3. `lock_o` rises on exactly the Nth successive in-window comparison. It stays high during further in-window comparisons, and it never rises except after an in-window comparison.
- R3: One out-of-window comparison sets `unlock_o` to 1, clears `lock_o` and restarts the run at zero, all in the cycle after the comparison.
- R4: `unlock_o` returns to 0 after the first in-window comparison. `lock_o` stays 0 until a full run of N comparisons has been counted again.
- R5: The distance is taken as a magnitude. The same thresholds apply whether the reference edge or the feedback edge comes first.
- R6: If the second edge has not come after T cycles, the comparison is reported out of window without waiting for it. The late edge is then discarded and does not start a new measurement.
- R7: While `enable_i` is 0, both flags are 0, comparisons are ignored, and the run restarts from zero.
- R8: Any change of `win_sel_i` or `cnt_sel_i` clears `lock_o` in the following cycle and restarts the run.
- R9: After reset both flags are 0. `lock_o` and `unlock_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Detector enable |
| ref_div_i | input | 1 | Reference-divider output (asynchronous) |
| fb_div_i | input | 1 | Feedback-divider output (asynchronous) |
| win_sel_i | input | 2 | Phase window select |
| cnt_sel_i | input | 2 | Successive-good-comparison count select |
| lock_o | output | 1 | Lock status flag |
| unlock_o | output | 1 | Out-of-lock status flag |

## Verification
The bench places edge pairs exactly at T-1 and T cycles apart for every window code. A design using `<=` instead of `<` would pass a pair that is T cycles apart, and one with a wrong threshold would misjudge a boundary pair. For every count code it checks `lock_o` after N-1 comparisons and again after the Nth, which exposes an off-by-one in the run counter or a wrong saturation value. It withholds the follower edge beyond the window to show that `unlock_o` rises early and that the late edge is not taken as a new leader; a design that paired it would report the next good pair as bad. It also drops the enable and changes the selects while locked, which catches a design that keeps a stale run or a stale flag.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_MEAS = 2'd1,
        MS_SKIP = 2'd2
    } meas_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/plm_edge_sync.sv
module plm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sig_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/plm_phase_meas.sv
module plm_phase_meas
    import plm_pkg::*;
#(
    parameter int WIN_T0 = 3,
    parameter int WIN_T1 = 10,
    parameter int WIN_T2 = 30,
    parameter int WIN_T3 = 90,
    parameter int PH_W   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic [1:0] win_sel_i,
    input  logic       ref_rise_i,
    input  logic       fb_rise_i,
    output logic       cmp_valid_o,
    output logic       cmp_good_o
);
    localparam logic [PH_W-1:0] TH0 = PH_W'(WIN_T0);
    localparam logic [PH_W-1:0] TH1 = PH_W'(WIN_T1);
    localparam logic [PH_W-1:0] TH2 = PH_W'(WIN_T2);
    localparam logic [PH_W-1:0] TH3 = PH_W'(WIN_T3);

    typedef struct packed {
        meas_state_e     st;
        logic            lead_ref;
        logic [PH_W-1:0] cnt;
        logic            valid;
        logic            good;
    } meas_t;

    meas_t m_d, m_q;
    logic [PH_W-1:0] thr;
    logic            lead_pulse, follow_pulse;

    always_comb begin
        case (win_sel_i)
            2'd0:    thr = TH0;
            2'd1:    thr = TH1;
            2'd2:    thr = TH2;
            default: thr = TH3;
        endcase
    end

    assign lead_pulse   = m_q.lead_ref ? ref_rise_i : fb_rise_i;
    assign follow_pulse = m_q.lead_ref ? fb_rise_i  : ref_rise_i;

    always_comb begin
        m_d       = m_q;
        m_d.valid = 1'b0;
        m_d.good  = 1'b0;
        if (!enable_i) begin
            m_d.st  = MS_IDLE;
            m_d.cnt = '0;
        end else begin
            case (m_q.st)
                MS_IDLE: begin
                    if (ref_rise_i && fb_rise_i) begin
                        m_d.valid = 1'b1;
                        m_d.good  = (thr != '0);
                    end else if (ref_rise_i || fb_rise_i) begin
                        m_d.st       = MS_MEAS;
                        m_d.lead_ref = ref_rise_i;
                        m_d.cnt      = PH_W'(1);
                    end
                end
                MS_MEAS: begin
                    if (follow_pulse) begin
                        m_d.valid = 1'b1;
                        m_d.good  = (m_q.cnt < thr);
                        m_d.st    = MS_IDLE;
                        m_d.cnt   = '0;
                    end else if (m_q.cnt >= thr) begin
                        m_d.valid = 1'b1;
                        m_d.good  = 1'b0;
                        m_d.st    = MS_SKIP;
                        m_d.cnt   = '0;
                    end else begin
                        m_d.cnt = m_q.cnt + PH_W'(1);
                    end
                end
                MS_SKIP: begin
                    if (follow_pulse) begin
                        m_d.st = MS_IDLE;
                    end else if (lead_pulse) begin
                        m_d.st  = MS_MEAS;
                        m_d.cnt = PH_W'(1);
                    end
                end
                default: m_d.st = MS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.st       <= MS_IDLE;
            m_q.lead_ref <= 1'b0;
            m_q.cnt      <= '0;
            m_q.valid    <= 1'b0;
            m_q.good     <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign cmp_valid_o = m_q.valid;
    assign cmp_good_o  = m_q.good;

endmodule

// File: rtl/plm_run_track.sv
module plm_run_track #(
    parameter int RUN_N0 = 32,
    parameter int RUN_N1 = 128,
    parameter int RUN_N2 = 512,
    parameter int RUN_N3 = 2048,
    parameter int RUN_W  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic [1:0] win_sel_i,
    input  logic [1:0] cnt_sel_i,
    input  logic       cmp_valid_i,
    input  logic       cmp_good_i,
    output logic       lock_o,
    output logic       unlock_o
);
    localparam logic [RUN_W-1:0] RN0 = RUN_W'(RUN_N0);
    localparam logic [RUN_W-1:0] RN1 = RUN_W'(RUN_N1);
    localparam logic [RUN_W-1:0] RN2 = RUN_W'(RUN_N2);
    localparam logic [RUN_W-1:0] RN3 = RUN_W'(RUN_N3);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
        logic             unlock;
        logic [1:0]       win_sel;
        logic [1:0]       cnt_sel;
    } trk_t;

    trk_t t_d, t_q;
    logic [RUN_W-1:0] target, run_inc;
    logic             cfg_change;

    always_comb begin
        case (cnt_sel_i)
            2'd0:    target = RN0;
            2'd1:    target = RN1;
            2'd2:    target = RN2;
            default: target = RN3;
        endcase
    end

    assign run_inc    = (t_q.run >= target) ? target : t_q.run + RUN_W'(1);
    assign cfg_change = (win_sel_i != t_q.win_sel) || (cnt_sel_i != t_q.cnt_sel);

    always_comb begin
        t_d         = t_q;
        t_d.win_sel = win_sel_i;
        t_d.cnt_sel = cnt_sel_i;
        if (!enable_i) begin
            t_d.run    = '0;
            t_d.lock   = 1'b0;
            t_d.unlock = 1'b0;
        end else begin
            if (cmp_valid_i) begin
                if (cmp_good_i) begin
                    t_d.run    = run_inc;
                    t_d.unlock = 1'b0;
                    t_d.lock   = (run_inc >= target);
                end else begin
                    t_d.run    = '0;
                    t_d.unlock = 1'b1;
                    t_d.lock   = 1'b0;
                end
            end
            if (cfg_change) begin
                t_d.run  = '0;
                t_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.run     <= '0;
            t_q.lock    <= 1'b0;
            t_q.unlock  <= 1'b0;
            t_q.win_sel <= 2'd0;
            t_q.cnt_sel <= 2'd0;
        end else begin
            t_q <= t_d;
        end
    end

    assign lock_o   = t_q.lock;
    assign unlock_o = t_q.unlock;

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import plm_pkg::*;
#(
    parameter int WIN_T0      = 3,
    parameter int WIN_T1      = 10,
    parameter int WIN_T2      = 30,
    parameter int WIN_T3      = 90,
    parameter int RUN_N0      = 32,
    parameter int RUN_N1      = 128,
    parameter int RUN_N2      = 512,
    parameter int RUN_N3      = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       ref_div_i,
    input  logic       fb_div_i,
    input  logic [1:0] win_sel_i,
    input  logic [1:0] cnt_sel_i,
    output logic       lock_o,
    output logic       unlock_o
);
    localparam int WIN_MAX = max_of4(WIN_T0, WIN_T1, WIN_T2, WIN_T3);
    localparam int RUN_MAX = max_of4(RUN_N0, RUN_N1, RUN_N2, RUN_N3);
    localparam int PH_W    = $clog2(WIN_MAX + 1) + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic [1:0] div_raw;
    logic [1:0] div_rise;
    logic       cmp_valid, cmp_good;

    assign div_raw = {fb_div_i, ref_div_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        plm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (div_raw[g]),
            .rise_o (div_rise[g])
        );
    end

    plm_phase_meas #(
        .WIN_T0(WIN_T0), .WIN_T1(WIN_T1), .WIN_T2(WIN_T2), .WIN_T3(WIN_T3),
        .PH_W  (PH_W)
    ) u_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .win_sel_i   (win_sel_i),
        .ref_rise_i  (div_rise[0]),
        .fb_rise_i   (div_rise[1]),
        .cmp_valid_o (cmp_valid),
        .cmp_good_o  (cmp_good)
    );

    plm_run_track #(
        .RUN_N0(RUN_N0), .RUN_N1(RUN_N1), .RUN_N2(RUN_N2), .RUN_N3(RUN_N3),
        .RUN_W (RUN_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .win_sel_i   (win_sel_i),
        .cnt_sel_i   (cnt_sel_i),
        .cmp_valid_i (cmp_valid),
        .cmp_good_i  (cmp_good),
        .lock_o      (lock_o),
        .unlock_o    (unlock_o)
    );

endmodule

// File: rtl/plm_checker.sv
module plm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic [1:0] win_sel_i,
    input logic [1:0] cnt_sel_i,
    input logic       cmp_valid,
    input logic       cmp_good,
    input logic       lock_o,
    input logic       unlock_o
);
    // R9
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_o && unlock_o));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!lock_o && !unlock_o));

    // R8
    cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel_i != $past(win_sel_i) || cnt_sel_i != $past(cnt_sel_i)) |=> !lock_o);

    // R3
    bad_sets_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cmp_valid && !cmp_good) |=> (unlock_o && !lock_o));

    // R4
    good_clears_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cmp_valid && cmp_good) |=> !unlock_o);

    // R2
    lock_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(cmp_valid && cmp_good));

endmodule

bind phase_lock_monitor plm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .win_sel_i (win_sel_i),
    .cnt_sel_i (cnt_sel_i),
    .cmp_valid (cmp_valid),
    .cmp_good  (cmp_good),
    .lock_o    (lock_o),
    .unlock_o  (unlock_o)
);

// File: tb/sim_phase_lock_monitor.sv
module sim_phase_lock_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b1;
    logic       ref_div_i = 1'b0;
    logic       fb_div_i = 1'b0;
    logic [1:0] win_sel_i = 2'd1;
    logic [1:0] cnt_sel_i = 2'd0;
    logic       lock_o, unlock_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phase_lock_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .ref_div_i (ref_div_i),
        .fb_div_i  (fb_div_i),
        .win_sel_i (win_sel_i),
        .cnt_sel_i (cnt_sel_i),
        .lock_o    (lock_o),
        .unlock_o  (unlock_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One comparison: leader rises, follower rises off cycles later.
    task automatic do_pair(input bit ref_leads, input int off);
        @(negedge clk);
        if (off == 0) begin
            ref_div_i = 1'b1;
            fb_div_i  = 1'b1;
        end else begin
            if (ref_leads) ref_div_i = 1'b1;
            else           fb_div_i  = 1'b1;
            wait_cycles(off);
            ref_div_i = 1'b1;
            fb_div_i  = 1'b1;
        end
        wait_cycles(3);
        ref_div_i = 1'b0;
        fb_div_i  = 1'b0;
        wait_cycles(3);
    endtask

    task automatic run_pairs(input int n, input bit ref_leads, input int off);
        for (int i = 0; i < n; i++) do_pair(ref_leads, off);
    endtask

    task automatic t_reset;
        check("R9", "lock after reset", lock_o, 1'b0);
        check("R9", "unlock after reset", unlock_o, 1'b0);
    endtask

    task automatic t_lock_run;
        run_pairs(31, 1'b1, 5);
        check("R2", "lock after 31 of 32", lock_o, 1'b0);
        do_pair(1'b1, 5);
        check("R2", "lock on 32nd", lock_o, 1'b1);
        run_pairs(5, 1'b1, 5);
        check("R2", "lock held past run", lock_o, 1'b1);
    endtask

    task automatic t_bad_then_good;
        do_pair(1'b1, 10);
        check("R3", "unlock on bad", unlock_o, 1'b1);
        check("R3", "lock cleared on bad", lock_o, 1'b0);
        do_pair(1'b1, 9);
        check("R4", "unlock cleared on good", unlock_o, 1'b0);
        check("R4", "lock still low after one good", lock_o, 1'b0);
        run_pairs(30, 1'b1, 9);
        check("R4", "lock low after 31 good", lock_o, 1'b0);
        do_pair(1'b1, 9);
        check("R4", "lock after full rerun", lock_o, 1'b1);
    endtask

    task automatic t_fb_leads;
        do_pair(1'b0, 9);
        check("R5", "fb leads by 9 in window", lock_o, 1'b1);
        check("R5", "fb leads by 9 no unlock", unlock_o, 1'b0);
        do_pair(1'b0, 10);
        check("R5", "fb leads by 10 unlock", unlock_o, 1'b1);
        run_pairs(32, 1'b0, 1);
        check("R5", "fb-lead run locks", lock_o, 1'b1);
    endtask

    task automatic t_windows;
        @(negedge clk); win_sel_i = 2'd0;
        wait_cycles(2);
        check("R8", "window change clears lock", lock_o, 1'b0);
        do_pair(1'b1, 2);
        check("R1", "code0 offset 2 good", unlock_o, 1'b0);
        do_pair(1'b1, 3);
        check("R1", "code0 offset 3 bad", unlock_o, 1'b1);
        @(negedge clk); win_sel_i = 2'd3;
        do_pair(1'b1, 89);
        check("R1", "code3 offset 89 good", unlock_o, 1'b0);
        do_pair(1'b0, 90);
        check("R1", "code3 offset 90 bad", unlock_o, 1'b1);
        @(negedge clk); win_sel_i = 2'd2;
        do_pair(1'b0, 29);
        check("R1", "code2 offset 29 good", unlock_o, 1'b0);
        do_pair(1'b1, 30);
        check("R1", "code2 offset 30 bad", unlock_o, 1'b1);
        @(negedge clk); win_sel_i = 2'd1;
        do_pair(1'b1, 0);
        check("R1", "code1 offset 0 good", unlock_o, 1'b0);
    endtask

    task automatic t_timeout;
        @(negedge clk); ref_div_i = 1'b1;
        wait_cycles(20);
        check("R6", "unlock before late edge", unlock_o, 1'b1);
        check("R6", "follower still absent", fb_div_i, 1'b0);
        fb_div_i = 1'b1;
        wait_cycles(3);
        ref_div_i = 1'b0;
        fb_div_i  = 1'b0;
        wait_cycles(3);
        do_pair(1'b1, 3);
        check("R6", "late edge discarded, next pair good", unlock_o, 1'b0);
    endtask

    task automatic t_enable;
        run_pairs(32, 1'b1, 4);
        check("R7", "locked before disable", lock_o, 1'b1);
        @(negedge clk); enable_i = 1'b0;
        wait_cycles(2);
        check("R7", "lock low when disabled", lock_o, 1'b0);
        do_pair(1'b1, 20);
        check("R7", "bad pair ignored when disabled", unlock_o, 1'b0);
        @(negedge clk); enable_i = 1'b1;
        run_pairs(31, 1'b1, 4);
        check("R7", "run restarted after enable", lock_o, 1'b0);
        do_pair(1'b1, 4);
        check("R7", "lock after full run on enable", lock_o, 1'b1);
    endtask

    task automatic t_counts;
        @(negedge clk); cnt_sel_i = 2'd1;
        wait_cycles(2);
        check("R8", "count change clears lock", lock_o, 1'b0);
        run_pairs(127, 1'b1, 5);
        check("R2", "code1 lock after 127", lock_o, 1'b0);
        do_pair(1'b1, 5);
        check("R2", "code1 lock on 128th", lock_o, 1'b1);
        @(negedge clk); cnt_sel_i = 2'd2;
        run_pairs(511, 1'b0, 5);
        check("R2", "code2 lock after 511", lock_o, 1'b0);
        do_pair(1'b0, 5);
        check("R2", "code2 lock on 512th", lock_o, 1'b1);
        @(negedge clk); cnt_sel_i = 2'd3;
        run_pairs(2047, 1'b1, 2);
        check("R2", "code3 lock after 2047", lock_o, 1'b0);
        do_pair(1'b1, 2);
        check("R2", "code3 lock on 2048th", lock_o, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_lock_run();
        t_bad_then_good();
        t_fb_leads();
        t_windows();
        t_timeout();
        t_enable();
        t_counts();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule